// File: doc/BRIEF.md
# Dual-Core Run Mode Controller

This block holds the machine-wide run mode of a two-core processor. The primary core always executes. The secondary core is gated off while the machine sits in reset mode and runs only in active mode. Each core's decoder hands the block one-cycle strobes for its START and RESET instructions. The block decides whether each strobe is legal in the current mode. From that decision it drives a run enable for the secondary core and a one-cycle load strobe with a fixed start address for the secondary's instruction pointer. It also drives the read-only identity value of each core.

A START takes effect only when it comes from the primary and only in reset mode. It sends the secondary to the first word of boot page 128, which is physical address 65536. A RESET from either core takes effect only in active mode. Every other combination leaves the state unchanged. The reset input is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `dcm_top`

## Requirements
- R1: While reset is held, and through the release of reset, `sec_run_en` is 0, `sec_ip_load` is 0 and `sec_ip_addr` is 0 (reset mode).
- R2: A `pri_start` sampled in reset mode sets `sec_run_en` to 1 at the next clock edge.
- R3: On an accepted START, `sec_ip_addr` becomes 65536 (0x0001_0000, page 128 of 512-word pages) at the same edge that raises `sec_run_en`, and it keeps that value afterwards.
- R4: A `pri_start` sampled in active mode has no effect: `sec_run_en` stays 1 and no load strobe is produced.
- R5: A `pri_reset` or a `sec_reset` sampled in active mode clears `sec_run_en` at the next edge.
- R6: A RESET strobe from either core sampled in reset mode has no effect: `sec_run_en` stays 0 and `sec_ip_load` stays 0.
- R7: `pri_core_id` always reads 0 and `sec_core_id` always reads 1.
- R8: A `sec_start` is ignored in every mode: it neither enables the secondary nor produces a load strobe.
- R9: When both cores assert RESET in the same active-mode cycle, the block makes one transition to reset mode and remains there.
- R10: `sec_ip_load` is high for exactly one cycle, the cycle after the accepted START. A `pri_start` held high for several cycles gives a single pulse.
- R11: If START and RESET arrive together, the START wins in reset mode (the RESET is illegal there) and the RESET wins in active mode (the START is illegal there).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pri_start | input | 1 | Decoded START strobe from the primary core |
| pri_reset | input | 1 | Decoded RESET strobe from the primary core |
| sec_start | input | 1 | Decoded START strobe from the secondary core |
| sec_reset | input | 1 | Decoded RESET strobe from the secondary core |
| sec_run_en | output | 1 | Secondary core run enable (1 = active mode) |
| sec_ip_load | output | 1 | One-cycle load strobe for the secondary's instruction pointer |
| sec_ip_addr | output | ADDR_W (32) | Start address for the secondary's instruction pointer |
| pri_core_id | output | ID_W (1) | Identity value of the primary core |
| sec_core_id | output | ID_W (1) | Identity value of the secondary core |

## Verification
Every result is one register stage from its stimulus. A strobe sampled at edge k shows up on `sec_run_en`, `sec_ip_load` and `sec_ip_addr` after edge k. The one exception is reset release, which takes two extra edges in the synchroniser before the first strobe can be accepted. The bench drives inputs at the falling edge. At each later falling edge it compares every output with a behavioural model, which is stepped at the rising edge with the same two-edge release delay. Each comparison is tagged with the requirement of the stimulus applied in the cycle before it.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

  localparam int unsigned NUM_CORES = 2;
  localparam int unsigned PRI_IDX   = 0;
  localparam int unsigned SEC_IDX   = 1;

  typedef enum logic {
    MODE_HALTED  = 1'b0,
    MODE_RUNNING = 1'b1
  } run_mode_e;

endpackage

// File: rtl/dcm_rst_sync.sv
module dcm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/dcm_req_filter.sv
module dcm_req_filter
  import dcm_pkg::*;
#(
  parameter int unsigned            N_CORES    = NUM_CORES,
  parameter logic [N_CORES-1:0]     START_MASK = N_CORES'(1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  run_mode_e          mode,
  input  logic [N_CORES-1:0] start_req,
  input  logic [N_CORES-1:0] halt_req,
  output logic               start_ok,
  output logic               halt_ok
);

  logic [N_CORES-1:0] start_gated;

  // only cores named in START_MASK may launch the secondary
  for (genvar c = 0; c < N_CORES; c++) begin : g_gate
    if (START_MASK[c]) begin : g_allowed
      assign start_gated[c] = start_req[c];
    end else begin : g_blocked
      assign start_gated[c] = 1'b0;
    end
  end

  always_comb begin
    start_ok = 1'b0;
    halt_ok  = 1'b0;
    unique case (mode)
      MODE_HALTED:  start_ok = |start_gated;
      MODE_RUNNING: halt_ok  = |halt_req;
      default: ;
    endcase
  end

  AST_NO_DUAL_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ok && halt_ok)) else $error("start and halt granted together"); // R11

endmodule

// File: rtl/dcm_mode_reg.sv
module dcm_mode_reg
  import dcm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_ok,
  input  logic      halt_ok,
  output run_mode_e mode_q
);

  run_mode_e mode_d;
  logic      mode_en;

  always_comb begin
    mode_en = start_ok | halt_ok;
    mode_d  = mode_q;
    if (halt_ok) begin
      mode_d = MODE_HALTED;
    end else if (start_ok) begin
      mode_d = MODE_RUNNING;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_HALTED;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  AST_HALT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    halt_ok |=> mode_q == MODE_HALTED) else $error("halt not taken"); // R5

  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> mode_q == MODE_RUNNING) else $error("start not taken"); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ok || halt_ok) |=> $stable(mode_q)) else $error("mode moved without grant"); // R6

endmodule

// File: rtl/dcm_ip_loader.sv
module dcm_ip_loader #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BOOT_PAGE = 128,
  parameter int unsigned PAGE_SZ   = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok,
  output logic              load_q,
  output logic [ADDR_W-1:0] addr_q
);

  localparam logic [ADDR_W-1:0] BOOT_ADDR = ADDR_W'(BOOT_PAGE * PAGE_SZ);

  logic              load_d;
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    load_d  = start_ok;
    addr_en = start_ok;
    addr_d  = BOOT_ADDR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
    end else begin
      load_q <= load_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |=> !load_q) else $error("load strobe longer than one cycle"); // R10

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> addr_q == BOOT_ADDR) else $error("wrong boot address"); // R3

endmodule

// File: rtl/dcm_top.sv
module dcm_top
  import dcm_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned ID_W      = 1,
  parameter int unsigned BOOT_PAGE = 128,
  parameter int unsigned PAGE_SZ   = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pri_start,
  input  logic              pri_reset,
  input  logic              sec_start,
  input  logic              sec_reset,
  output logic              sec_run_en,
  output logic              sec_ip_load,
  output logic [ADDR_W-1:0] sec_ip_addr,
  output logic [ID_W-1:0]   pri_core_id,
  output logic [ID_W-1:0]   sec_core_id
);

  localparam logic [NUM_CORES-1:0] START_FROM = NUM_CORES'(1) << PRI_IDX;

  logic                 rst_n_int;
  logic [NUM_CORES-1:0] start_vec;
  logic [NUM_CORES-1:0] halt_vec;
  logic                 start_ok;
  logic                 halt_ok;
  run_mode_e            mode_q;

  always_comb begin
    start_vec          = '0;
    halt_vec           = '0;
    start_vec[PRI_IDX] = pri_start;
    start_vec[SEC_IDX] = sec_start;
    halt_vec[PRI_IDX]  = pri_reset;
    halt_vec[SEC_IDX]  = sec_reset;
  end

  dcm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  dcm_req_filter #(.N_CORES(NUM_CORES), .START_MASK(START_FROM)) u_filter (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .mode      (mode_q),
    .start_req (start_vec),
    .halt_req  (halt_vec),
    .start_ok  (start_ok),
    .halt_ok   (halt_ok)
  );

  dcm_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start_ok (start_ok),
    .halt_ok  (halt_ok),
    .mode_q   (mode_q)
  );

  dcm_ip_loader #(.ADDR_W(ADDR_W), .BOOT_PAGE(BOOT_PAGE), .PAGE_SZ(PAGE_SZ)) u_ip (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start_ok (start_ok),
    .load_q   (sec_ip_load),
    .addr_q   (sec_ip_addr)
  );

  assign sec_run_en  = (mode_q == MODE_RUNNING);
  assign pri_core_id = ID_W'(PRI_IDX);
  assign sec_core_id = ID_W'(SEC_IDX);

  AST_LOAD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n_int)
    sec_ip_load |-> sec_run_en && !$past(sec_run_en)) else $error("load without launch"); // R10

  AST_SEC_START_DEAD: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!sec_run_en && sec_start && !pri_start) |=> !sec_run_en && !sec_ip_load)
    else $error("secondary start honoured"); // R8

  AST_ACTIVE_START_DEAD: assert property (@(posedge clk) disable iff (!rst_n_int)
    (sec_run_en && pri_start && !pri_reset && !sec_reset) |=> sec_run_en && !sec_ip_load)
    else $error("start honoured in active mode"); // R4

  AST_EITHER_HALT: assert property (@(posedge clk) disable iff (!rst_n_int)
    (sec_run_en && (pri_reset || sec_reset)) |=> !sec_run_en)
    else $error("reset not honoured"); // R9

endmodule

// File: tb/tb_dcm_top.sv
`timescale 1ns/1ps
module tb_dcm_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pri_start = 1'b0, pri_reset = 1'b0, sec_start = 1'b0, sec_reset = 1'b0;
  logic        sec_run_en, sec_ip_load;
  logic [31:0] sec_ip_addr;
  logic [0:0]  pri_core_id, sec_core_id;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc_cnt = 0;
  string tag = "R1";

  // behavioural reference
  int          m_rel = 0;
  bit          m_run = 0;
  bit          m_load = 0;
  logic [31:0] m_addr = 0;

  always #5 clk = ~clk;

  dcm_top dut (
    .clk(clk), .rst_n(rst_n),
    .pri_start(pri_start), .pri_reset(pri_reset),
    .sec_start(sec_start), .sec_reset(sec_reset),
    .sec_run_en(sec_run_en), .sec_ip_load(sec_ip_load), .sec_ip_addr(sec_ip_addr),
    .pri_core_id(pri_core_id), .sec_core_id(sec_core_id)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rel = 0; m_run = 0; m_load = 0; m_addr = 0;
    end else if (m_rel < 2) begin
      m_rel = m_rel + 1;
    end else begin
      m_load = 0;
      if (!m_run) begin
        if (pri_start) begin
          m_run = 1; m_load = 1; m_addr = 32'd65536;
        end
      end else if (pri_reset || sec_reset) begin
        m_run = 0;
      end
    end
  end

  task automatic cmp(input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    cmp("sec_run_en", sec_run_en, m_run);
    cmp("sec_ip_load", sec_ip_load, m_load);
    cmp("sec_ip_addr", sec_ip_addr, m_addr);
    cmp("pri_core_id (R7)", pri_core_id, 0);
    cmp("sec_core_id (R7)", sec_core_id, 1);
  endtask

  // check the previous cycle's result, then apply new strobes
  task automatic cyc(input bit ps, input bit pr, input bit ss, input bit sr, input string t);
    @(negedge clk);
    check_all();
    pri_start = ps; pri_reset = pr; sec_start = ss; sec_reset = sr;
    tag = t;
  endtask

  initial begin
    repeat (3) cyc(0, 0, 0, 0, "R1");
    rst_n = 1'b1;
    repeat (4) cyc(0, 0, 0, 0, "R1");
    cyc(0, 1, 0, 0, "R6");
    cyc(0, 0, 0, 1, "R6");
    cyc(0, 1, 0, 1, "R6");
    cyc(0, 0, 1, 0, "R8");
    cyc(0, 0, 1, 1, "R8");
    cyc(0, 0, 0, 0, "R8");
    cyc(1, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, "R3");
    cyc(1, 0, 0, 0, "R4");
    cyc(1, 0, 1, 0, "R4");
    cyc(0, 0, 1, 0, "R8");
    cyc(0, 1, 0, 0, "R5");
    cyc(0, 0, 0, 0, "R5");
    cyc(1, 0, 0, 0, "R2");
    cyc(0, 0, 0, 1, "R5");
    cyc(0, 0, 0, 0, "R5");
    cyc(1, 0, 0, 0, "R2");
    cyc(0, 1, 0, 1, "R9");
    cyc(0, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, "R9");
    cyc(1, 1, 0, 0, "R11");
    cyc(0, 0, 0, 0, "R11");
    cyc(1, 0, 0, 1, "R11");
    cyc(0, 0, 0, 0, "R11");
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, "R10");
    // asynchronous reset from active mode
    @(negedge clk);
    check_all();
    rst_n = 1'b0;
    tag = "R1";
    #2;
    cmp("sec_run_en async clear (R1)", sec_run_en, 0);
    cyc(1, 0, 0, 0, "R1");
    rst_n = 1'b1;
    cyc(1, 0, 0, 0, "R1");
    cyc(1, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, "R3");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc_cnt++;
      if (cyc_cnt > 5000) begin
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected under 5000", cyc_cnt);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

endmodule